// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Interrupt

This peripheral keeps wall time as a 32-bit count of whole seconds. An internal prescaler divides the bus clock down to a once-per-second enable. On each such tick the counter moves forward by one. Software reaches the block through a simple zero-wait register bus with a setup phase and an access phase. Over that bus it reads the running count, arms a new starting value and sets a comparison value.

A starting value written by software is not copied straight into the counter. It waits as a pending load and takes the place of the normal increment on the next one-second tick. The count that results from a tick is compared with the comparison register. On equality a raw event flag is latched. The interrupt line shows that flag only while the enable bit is set and the mask bit is clear. Reading the acknowledge register returns the flag and clears it.

Top module: `sec_rtc`

## Requirements
- R1: After reset the count, the comparison value, the load value, the control word, the raw flag and `irq_o` are all zero.
- R2: While control bit 2 (run) is set, the count changes exactly once every PRESCALE clock cycles. The first change comes PRESCALE cycles after run was set. While run is clear, the count does not change.
- R3: A write to the load register (offset 0x08) leaves the count unchanged until the next one-second tick. At that tick the count takes the written value.
- R4: On a tick with a load pending, the loaded value replaces the increment. That loaded value is then compared with the comparison register (offset 0x04).
- R5: When the count produced by a tick equals the comparison value, bit 0 of the raw status register (offset 0x14) becomes 1 on the following cycle, whatever the enable and mask bits are.
- R6: `irq_o` and bit 0 of the masked status register (offset 0x10) equal raw AND control bit 0 (enable) AND NOT control bit 1 (mask).
- R7: A read of the acknowledge register (offset 0x18) returns the raw flag in bit 0 and clears the flag after the access. A match on the same cycle takes precedence over the clear.
- R8: A tick at count 0xFFFFFFFF with control bit 3 (wrap) set gives 0. With wrap clear, the count stays at 0xFFFFFFFF.
- R9: Offset 0x1C reads the VERSION parameter. Offsets at or above 0x20 read 0. Writes to 0x00, 0x10, 0x14, 0x18 and 0x1C change nothing.
- R10: Offset 0x00 reads the count. Offsets 0x04, 0x08 and 0x0C (bits 3:0) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | AW | Byte address; bits 1:0 are ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| irq_o | output | 1 | Gated match interrupt, level |

## Verification
The bench builds the block with PRESCALE set to 4 and a distinctive VERSION value. The short tick period puts pending loads, loads that coincide with ticks, acknowledge reads that meet a new match, and both rollover modes at 0xFFFFFFFF within a few hundred cycles each. With AW at 6, the bench can address offsets above the register map and check that those reads return zero.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // word index of each register (byte offset / 4)
  typedef enum logic [2:0] {
    W_COUNT = 3'd0,
    W_MATCH = 3'd1,
    W_LOAD  = 3'd2,
    W_CTRL  = 3'd3,
    W_MSTAT = 3'd4,
    W_RSTAT = 3'd5,
    W_ACK   = 3'd6,
    W_VER   = 3'd7
  } rtc_word_e;

  // control word, bit 0 at the right
  typedef struct packed {
    logic wrap;  // bit 3
    logic run;   // bit 2
    logic mask;  // bit 1
    logic ie;    // bit 0
  } rtc_ctrl_t;

  localparam int unsigned CTRL_W = 4;

  function automatic logic irq_gate(input logic raw, input rtc_ctrl_t c);
    return raw & c.ie & ~c.mask;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pcnt;

  assign tick_o = run_i && (pcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (!run_i || tick_o) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wrap_i,
  input  logic          load_wr_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] match_i,
  output logic [CW-1:0] cnt_o,
  output logic          pend_o,
  output logic          load_apply_o,
  output logic          match_evt_o
);
  localparam logic [CW-1:0] TOP = '1;

  function automatic logic [CW-1:0] advance(input logic [CW-1:0] c, input logic wrap);
    if (c == TOP) return wrap ? '0 : TOP;
    return c + 1'b1;
  endfunction

  logic [CW-1:0] nxt;

  always_comb nxt = pend_o ? load_val_i : advance(cnt_o, wrap_i);

  assign load_apply_o = tick_i & pend_o;
  assign match_evt_o  = tick_i & (nxt == match_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (tick_i) cnt_o <= nxt;
      if (load_wr_i)         pend_o <= 1'b1;
      else if (load_apply_o) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_i,
  input  logic      clr_i,
  input  rtc_ctrl_t ctrl_i,
  output logic      raw_o,
  output logic      masked_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_o <= 1'b0;
    else if (set_i)  raw_o <= 1'b1;
    else if (clr_i)  raw_o <= 1'b0;
  end

  assign masked_o = irq_gate(raw_o, ctrl_i);
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 6,
  parameter logic [31:0] VERSION = 32'h0001_0300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  input  logic [DW-1:0] cnt_i,
  input  logic          raw_i,
  input  logic          masked_i,
  output rtc_ctrl_t     ctrl_o,
  output logic [DW-1:0] match_o,
  output logic [DW-1:0] load_o,
  output logic          load_wr_o,
  output logic          ack_rd_o
);
  logic      in_map;
  rtc_word_e word;
  logic      acc, wr, rd;

  generate
    if (AW > 5) begin : g_hi
      assign in_map = ~|paddr[AW-1:5];
    end else begin : g_nohi
      assign in_map = 1'b1;
    end
  endgenerate

  assign word = rtc_word_e'(paddr[4:2]);
  assign acc  = psel & penable & in_map;
  assign wr   = acc & pwrite;
  assign rd   = acc & ~pwrite;

  assign load_wr_o = wr && (word == W_LOAD);
  assign ack_rd_o  = rd && (word == W_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o  <= '0;
      match_o <= '0;
      load_o  <= '0;
    end else if (wr) begin
      case (word)
        W_CTRL:  ctrl_o  <= rtc_ctrl_t'(pwdata[CTRL_W-1:0]);
        W_MATCH: match_o <= pwdata;
        W_LOAD:  load_o  <= pwdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    prdata = '0;
    if (in_map) begin
      case (word)
        W_COUNT: prdata = cnt_i;
        W_MATCH: prdata = match_o;
        W_LOAD:  prdata = load_o;
        W_CTRL:  prdata = DW'(ctrl_o);
        W_MSTAT: prdata = DW'(masked_i);
        W_RSTAT: prdata = DW'(raw_i);
        W_ACK:   prdata = DW'(raw_i);
        W_VER:   prdata = DW'(VERSION);
        default: prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned PRESCALE = 32768,
  parameter int unsigned AW       = 6,
  parameter logic [31:0] VERSION  = 32'h0001_0300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          irq_o
);
  localparam int unsigned DW = 32;

  rtc_ctrl_t     ctrl_w;
  logic [DW-1:0] match_w, load_val_w, cnt_w;
  logic          load_wr_w, ack_rd_w, tick_w;
  logic          pend_w, load_apply_w, match_evt_w, raw_w, masked_w;

  rtc_regs #(.DW(DW), .AW(AW), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .cnt_i(cnt_w), .raw_i(raw_w), .masked_i(masked_w),
    .ctrl_o(ctrl_w), .match_o(match_w), .load_o(load_val_w),
    .load_wr_o(load_wr_w), .ack_rd_o(ack_rd_w)
  );

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl_w.run), .tick_o(tick_w)
  );

  rtc_counter #(.CW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .wrap_i(ctrl_w.wrap),
    .load_wr_i(load_wr_w), .load_val_i(load_val_w), .match_i(match_w),
    .cnt_o(cnt_w), .pend_o(pend_w), .load_apply_o(load_apply_w),
    .match_evt_o(match_evt_w)
  );

  rtc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(match_evt_w), .clr_i(ack_rd_w),
    .ctrl_i(ctrl_w), .raw_o(raw_w), .masked_o(masked_w)
  );

  assign irq_o = masked_w;
endmodule

// File: rtl/rtc_sva.sv
module rtc_sva
  import rtc_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          pend,
  input logic          load_apply,
  input logic          match_evt,
  input logic          ack_rd,
  input logic          raw,
  input logic          irq,
  input rtc_ctrl_t     ctrl,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] load_val
);
  localparam logic [CW-1:0] TOP = '1;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend && cnt != TOP) |=> cnt == CW'($past(cnt) + 1'b1));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_apply |=> cnt == $past(load_val));

  p_raw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> raw);

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.ie || ctrl.mask) |-> !irq);

  p_irq_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> raw);

  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !match_evt) |=> !raw);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend && ctrl.wrap && cnt == TOP) |=> cnt == '0);

  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend && !ctrl.wrap && cnt == TOP) |=> cnt == TOP);
endmodule

bind sec_rtc rtc_sva #(.CW(32)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .pend(pend_w),
  .load_apply(load_apply_w), .match_evt(match_evt_w), .ack_rd(ack_rd_w),
  .raw(raw_w), .irq(irq_o), .ctrl(ctrl_w), .cnt(cnt_w), .load_val(load_val_w)
);

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          P          = 4;
  localparam int          AW         = 6;
  localparam logic [31:0] VER        = 32'hA5C3_0102;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_rtc #(.PRESCALE(P), .AW(AW), .VERSION(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o)
  );

  // reference model built from the requirements
  logic [31:0] m_cnt, m_match, m_load;
  logic [3:0]  m_ctrl;
  logic        m_pend, m_raw;
  int          m_pre;

  always @(posedge clk) begin : model
    logic        tk, hit, acc, inmap;
    logic [31:0] nv;
    int          w;
    if (!rst_n) begin
      m_cnt <= 0; m_match <= 0; m_load <= 0; m_ctrl <= 0;
      m_pend <= 0; m_raw <= 0; m_pre <= 0;
    end else begin
      tk    = m_ctrl[2] && (m_pre == P-1);
      hit   = 1'b0;
      acc   = psel && penable;
      inmap = !paddr[5];
      w     = int'(paddr[4:2]);
      nv    = m_cnt;
      m_pre <= (m_ctrl[2] && !tk) ? m_pre + 1 : 0;
      if (tk) begin
        if (m_pend) nv = m_load;
        else if (m_cnt == 32'hFFFF_FFFF) nv = m_ctrl[3] ? 32'd0 : m_cnt;
        else nv = m_cnt + 1;
        m_cnt <= nv;
        hit = (nv == m_match);
      end
      if (acc && pwrite && inmap && w == 2) m_pend <= 1'b1;
      else if (tk) m_pend <= 1'b0;
      if (acc && pwrite && inmap) begin
        if (w == 1) m_match <= pwdata;
        if (w == 2) m_load  <= pwdata;
        if (w == 3) m_ctrl  <= pwdata[3:0];
      end
      if (hit) m_raw <= 1'b1;
      else if (acc && !pwrite && inmap && w == 6) m_raw <= 1'b0;
    end
  end

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    if (a[5]) return 32'd0;
    case (a[4:2])
      3'd0: return m_cnt;
      3'd1: return m_match;
      3'd2: return m_load;
      3'd3: return {28'd0, m_ctrl};
      3'd4: return {31'd0, m_raw & m_ctrl[0] & ~m_ctrl[1]};
      3'd5: return {31'd0, m_raw};
      3'd6: return {31'd0, m_raw};
      default: return VER;
    endcase
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    if (a[5]) return "R9";
    case (a[4:2])
      3'd0: return "R2";
      3'd4: return "R6";
      3'd5: return "R5";
      3'd6: return "R7";
      3'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    d = prdata;
    check(tag_of(a), prdata, exp_read(a));
    check("R6", {31'd0, irq_o}, {31'd0, m_raw & m_ctrl[0] & ~m_ctrl[1]});
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_read(6'h00, d); check("R1", d, 0);
    bus_read(6'h0C, d); check("R1", d, 0);
    bus_read(6'h14, d); check("R1", d, 0);
    bus_read(6'h08, d); check("R1", d, 0);
    check("R1", {31'd0, irq_o}, 0);

    // R9 version, unmapped, read-only writes
    bus_read(6'h1C, d); check("R9", d, VER);
    bus_read(6'h24, d); check("R9", d, 0);
    bus_write(6'h00, 32'hDEAD_BEEF);
    bus_write(6'h1C, 32'h1234_5678);
    bus_write(6'h14, 32'h1);
    bus_read(6'h00, d); check("R9", d, 0);
    bus_read(6'h1C, d); check("R9", d, VER);
    bus_read(6'h14, d); check("R9", d, 0);

    // R2 counting while run set, stall while clear
    bus_write(6'h0C, 32'h4);
    idle(3*P);
    bus_read(6'h00, d); check("R2", {31'd0, d != 0}, 1);
    bus_write(6'h0C, 32'h0);
    bus_read(6'h00, d);
    idle(3*P);
    begin
      logic [31:0] d2;
      bus_read(6'h00, d2); check("R2", d2, d);
    end

    // R3 load is deferred
    bus_write(6'h0C, 32'h4);
    bus_write(6'h08, 32'h0000_1000);
    if (m_pend) begin
      bus_read(6'h00, d);
      if (m_pend) check("R3", {31'd0, d == 32'h1000}, 0);
    end
    while (m_pend) @(negedge clk);
    bus_read(6'h00, d);

    // R4 / R5 / R6 / R7 match on a loaded value
    bus_write(6'h04, 32'h0000_2000);
    bus_write(6'h08, 32'h0000_2000);
    while (m_pend) @(negedge clk);
    idle(1);
    bus_read(6'h14, d); check("R5", d, 1);
    check("R4", {31'd0, irq_o}, 0);
    bus_write(6'h0C, 32'h5);
    bus_read(6'h10, d); check("R6", d, 1);
    check("R6", {31'd0, irq_o}, 1);
    bus_write(6'h0C, 32'h7);
    bus_read(6'h10, d); check("R6", d, 0);
    bus_write(6'h0C, 32'h5);
    bus_read(6'h18, d); check("R7", d, 1);
    bus_read(6'h14, d); check("R7", d, 0);

    // R8 rollover with wrap set
    bus_write(6'h0C, 32'hC);
    bus_write(6'h08, 32'hFFFF_FFFF);
    while (m_pend) @(negedge clk);
    idle(P);
    bus_read(6'h00, d); check("R8", {31'd0, d < 32'h10}, 1);
    // R8 saturation with wrap clear
    bus_write(6'h0C, 32'h4);
    bus_write(6'h08, 32'hFFFF_FFFF);
    while (m_pend) @(negedge clk);
    idle(3*P);
    bus_read(6'h00, d); check("R8", d, 32'hFFFF_FFFF);

    // constrained random traffic against the model
    for (int i = 0; i < 500; i++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0, 1: bus_read(AW'($urandom_range(0, 15) << 2), d);
        2: bus_write(6'h0C, ($urandom_range(0, 15) & 32'hF) | 32'h4);
        3: bus_write(6'h04, m_cnt + $urandom_range(0, 3));
        4: begin
          if ($urandom_range(0, 3) == 0) bus_write(6'h08, 32'hFFFF_FFFF - $urandom_range(0, 2));
          else bus_write(6'h08, $urandom);
        end
        5: bus_write(AW'((4 + $urandom_range(0, 4)) << 2) & 6'h3C, $urandom);
        6: bus_read(6'h18, d);
        default: idle($urandom_range(0, 2*P));
      endcase
    end
    bus_read(6'h00, d);

    summary();
    $finish;
  end
endmodule